// File: doc/BRIEF.md
# Fault Isolation Register Unit

This block collects error pulses from functional logic into a bank of fault registers, one set of registers per unit. Each unit holds a 64-bit sticky fault register, a mask register and two action registers. A one-cycle pulse on any error input bit latches the matching fault bit, and the bit stays set until software clears it. Software reaches all registers through a request/response port with a valid/ready handshake. Aliased write offsets let software clear fault bits by writing zeros (AND) and add mask bits by writing ones (OR), so it never has to do a read-modify-write.

Each unmasked fault bit is routed by its two-bit action code (act1, act0) to one of two attention classes. Code 00 selects checkstop, code 10 selects recoverable, and any code with act0 set raises no attention. A registered summary vector has one bit per unit for each class, and each of the two attention outputs is the OR of its summary vector. Firmware uses the summary to find which unit to analyse first.

Top module: `fir_bank`

## Requirements
- R1: After reset every fault register reads 0, every mask register reads all ones, both action registers read 0, both summary vectors are 0, both attention outputs are low and req_ready is high.
- R2: A one-cycle pulse on err_in bit (unit*64 + b) sets bit b of that unit's fault register, and the bit stays set through later idle cycles.
- R3: A write to offset 1 sets the fault register to its current value ANDed with the write data. An error pulse in the same cycle as that write leaves its bit set.
- R4: A write to offset 0 replaces the fault register and a write to offset 3 replaces the mask register. Reads of offset 1 return the fault register and reads of offset 5 return the mask register.
- R5: A write to offset 5 sets the mask register to its current value ORed with the write data.
- R6: A unit's chk_summary bit is 1 exactly when some bit has fault=1, mask=0, act0=0 and act1=0. The summary follows a register change one cycle later. Action 0 is at offset 6 and action 1 is at offset 7.
- R7: A unit's rec_summary bit is 1 exactly when some bit has fault=1, mask=0, act0=0 and act1=1.
- R8: A fault bit whose act0 is 1 (code 01 or 11) contributes to neither summary.
- R9: The request address is {unit, offset[2:0]}, so unit u occupies addresses u*8 to u*8+7. Bit u of each summary vector reflects unit u only.
- R10: Every accepted request (req_valid and req_ready) yields rsp_valid for exactly one cycle in the next cycle. A write returns rsp_rdata 0, and rsp_valid is low at all other times.
- R11: An access to offset 2 or 4 returns rsp_rdata 0 with rsp_err 1 and changes no register. Mapped accesses return rsp_err 0.
- R12: chk_attn equals the OR of chk_summary and rec_attn equals the OR of rec_summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_in | input | NUM_UNITS*DATA_W | Error pulses, unit u at bits u*DATA_W upward |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | UNIT_W+3 | {unit, register offset} |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata | output | DATA_W | Read data, 0 for writes and errors |
| rsp_err | output | 1 | Access to an unmapped offset |
| chk_attn | output | 1 | Any checkstop attention |
| rec_attn | output | 1 | Any recoverable attention |
| chk_summary | output | NUM_UNITS | Per-unit checkstop attention |
| rec_summary | output | NUM_UNITS | Per-unit recoverable attention |

## Verification
The assertions assume that req_valid is low while rst is high, so that a response is owed only for requests made after reset. The bench drives requests only after reset is released and req_ready has risen. The sticky-bit assertion assumes that a summary bit can fall only because of a register write accepted two cycles before. This holds because err_in can only set fault bits, so the bench is free to pulse err_in at any time, including in the same cycle as a clearing write.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam int OFS_W = 3;

  localparam logic [OFS_W-1:0] OFS_FAULT     = 3'd0;
  localparam logic [OFS_W-1:0] OFS_FAULT_AND = 3'd1;
  localparam logic [OFS_W-1:0] OFS_MASK      = 3'd3;
  localparam logic [OFS_W-1:0] OFS_MASK_OR   = 3'd5;
  localparam logic [OFS_W-1:0] OFS_ACT0      = 3'd6;
  localparam logic [OFS_W-1:0] OFS_ACT1      = 3'd7;

  function automatic logic ofs_mapped(input logic [OFS_W-1:0] o);
    case (o)
      OFS_FAULT, OFS_FAULT_AND, OFS_MASK,
      OFS_MASK_OR, OFS_ACT0, OFS_ACT1: return 1'b1;
      default:                         return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fir_decode.sv
module fir_decode #(
  parameter int NUM_UNITS = 4,
  parameter int UNIT_W    = 2,
  localparam int ADDR_W   = UNIT_W + fir_pkg::OFS_W
) (
  input  logic                      accept_i,
  input  logic                      write_i,
  input  logic [ADDR_W-1:0]         addr_i,
  output logic [UNIT_W-1:0]         unit_o,
  output logic [fir_pkg::OFS_W-1:0] ofs_o,
  output logic                      hit_o,
  output logic [NUM_UNITS-1:0]      wr_sel_o
);
  logic unit_ok;

  assign unit_o  = addr_i[ADDR_W-1:fir_pkg::OFS_W];
  assign ofs_o   = addr_i[fir_pkg::OFS_W-1:0];
  assign unit_ok = (32'(unit_o) < 32'(NUM_UNITS));
  assign hit_o   = unit_ok && fir_pkg::ofs_mapped(ofs_o);

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_sel
    assign wr_sel_o[i] = accept_i && write_i && hit_o && (unit_o == UNIT_W'(i));
  end
endmodule

// File: rtl/fir_unit.sv
module fir_unit #(
  parameter int DATA_W = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [DATA_W-1:0]         err_i,
  input  logic                      wr_en_i,
  input  logic [fir_pkg::OFS_W-1:0] wr_ofs_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         fault_o,
  output logic [DATA_W-1:0]         mask_o,
  output logic [DATA_W-1:0]         act0_o,
  output logic [DATA_W-1:0]         act1_o
);
  import fir_pkg::*;

  logic [DATA_W-1:0] fault_base, fault_nxt, mask_nxt;

  // software update first, then error pulses OR in so they win
  always_comb begin
    fault_base = fault_o;
    if (wr_en_i && wr_ofs_i == OFS_FAULT)     fault_base = wdata_i;
    if (wr_en_i && wr_ofs_i == OFS_FAULT_AND) fault_base = fault_o & wdata_i;
    fault_nxt = fault_base | err_i;
  end

  always_comb begin
    mask_nxt = mask_o;
    if (wr_en_i && wr_ofs_i == OFS_MASK)    mask_nxt = wdata_i;
    if (wr_en_i && wr_ofs_i == OFS_MASK_OR) mask_nxt = mask_o | wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_o <= '0;
      mask_o  <= '1;
      act0_o  <= '0;
      act1_o  <= '0;
    end else begin
      fault_o <= fault_nxt;
      mask_o  <= mask_nxt;
      if (wr_en_i && wr_ofs_i == OFS_ACT0) act0_o <= wdata_i;
      if (wr_en_i && wr_ofs_i == OFS_ACT1) act1_o <= wdata_i;
    end
  end
endmodule

// File: rtl/fir_classify.sv
module fir_classify #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] fault_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] act0_i,
  input  logic [DATA_W-1:0] act1_i,
  output logic              chk_o,
  output logic              rec_o
);
  logic [DATA_W-1:0] live;

  assign live  = fault_i & ~mask_i & ~act0_i;
  assign chk_o = |(live & ~act1_i);
  assign rec_o = |(live &  act1_i);
endmodule

// File: rtl/fir_bank.sv
module fir_bank #(
  parameter int NUM_UNITS = 4,
  parameter int DATA_W    = 64,
  localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int ADDR_W   = UNIT_W + fir_pkg::OFS_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_UNITS*DATA_W-1:0]   err_in,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_rdata,
  output logic                          rsp_err,
  output logic                          chk_attn,
  output logic                          rec_attn,
  output logic [NUM_UNITS-1:0]          chk_summary,
  output logic [NUM_UNITS-1:0]          rec_summary
);
  import fir_pkg::*;

  logic                   accept;
  logic [UNIT_W-1:0]      unit_idx;
  logic [OFS_W-1:0]       ofs;
  logic                   hit;
  logic [NUM_UNITS-1:0]   wr_sel;
  logic [DATA_W-1:0]      fault_a [NUM_UNITS];
  logic [DATA_W-1:0]      mask_a  [NUM_UNITS];
  logic [DATA_W-1:0]      act0_a  [NUM_UNITS];
  logic [DATA_W-1:0]      act1_a  [NUM_UNITS];
  logic [NUM_UNITS-1:0]   chk_vec, rec_vec;
  logic [DATA_W-1:0]      rd_val;

  assign accept = req_valid && req_ready;

  fir_decode #(.NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W)) u_decode (
    .accept_i (accept),
    .write_i  (req_write),
    .addr_i   (req_addr),
    .unit_o   (unit_idx),
    .ofs_o    (ofs),
    .hit_o    (hit),
    .wr_sel_o (wr_sel)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    fir_unit #(.DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst      (rst),
      .err_i    (err_in[u*DATA_W +: DATA_W]),
      .wr_en_i  (wr_sel[u]),
      .wr_ofs_i (ofs),
      .wdata_i  (req_wdata),
      .fault_o  (fault_a[u]),
      .mask_o   (mask_a[u]),
      .act0_o   (act0_a[u]),
      .act1_o   (act1_a[u])
    );

    fir_classify #(.DATA_W(DATA_W)) u_class (
      .fault_i (fault_a[u]),
      .mask_i  (mask_a[u]),
      .act0_i  (act0_a[u]),
      .act1_i  (act1_a[u]),
      .chk_o   (chk_vec[u]),
      .rec_o   (rec_vec[u])
    );
  end

  // read mux: aliases return the register they modify
  always_comb begin
    rd_val = '0;
    if (hit) begin
      case (ofs)
        OFS_FAULT, OFS_FAULT_AND: rd_val = fault_a[unit_idx];
        OFS_MASK, OFS_MASK_OR:    rd_val = mask_a[unit_idx];
        OFS_ACT0:                 rd_val = act0_a[unit_idx];
        OFS_ACT1:                 rd_val = act1_a[unit_idx];
        default:                  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      req_ready <= 1'b1;
      rsp_valid <= accept;
      rsp_err   <= accept && !hit;
      rsp_rdata <= (accept && !req_write) ? rd_val : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_summary <= '0;
      rec_summary <= '0;
      chk_attn    <= 1'b0;
      rec_attn    <= 1'b0;
    end else begin
      chk_summary <= chk_vec;
      rec_summary <= rec_vec;
      chk_attn    <= |chk_vec;
      rec_attn    <= |rec_vec;
    end
  end
endmodule

// File: rtl/fir_bank_chk.sv
module fir_bank_chk #(
  parameter int NUM_UNITS = 4,
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_write,
  input logic                 rsp_valid,
  input logic [DATA_W-1:0]    rsp_rdata,
  input logic                 rsp_err,
  input logic                 chk_attn,
  input logic                 rec_attn,
  input logic [NUM_UNITS-1:0] chk_summary,
  input logic [NUM_UNITS-1:0] rec_summary
);
  // R10
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  // R10
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);

  // R11
  err_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));

  // R12
  chk_attn_or_chk: assert property (@(posedge clk) disable iff (rst)
    chk_attn == (|chk_summary));

  // R12
  rec_attn_or_chk: assert property (@(posedge clk) disable iff (rst)
    rec_attn == (|rec_summary));

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_sticky
    // R2
    chk_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(chk_summary[u]) |-> $past(req_valid && req_ready && req_write, 2));
    // R2
    rec_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rec_summary[u]) |-> $past(req_valid && req_ready && req_write, 2));
  end
endmodule

bind fir_bank fir_bank_chk #(.NUM_UNITS(NUM_UNITS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .rsp_err     (rsp_err),
  .chk_attn    (chk_attn),
  .rec_attn    (rec_attn),
  .chk_summary (chk_summary),
  .rec_summary (rec_summary)
);

// File: tb/fir_bank_tb.sv
`timescale 1ns/1ps
module fir_bank_tb;
  localparam int NU = 4;
  localparam int DW = 64;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NU*DW-1:0] err_in = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, chk_attn, rec_attn;
  logic [DW-1:0] rsp_rdata;
  logic [NU-1:0] chk_summary, rec_summary;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fir_bank u_dut (
    .clk(clk), .rst(rst), .err_in(err_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .chk_attn(chk_attn), .rec_attn(rec_attn),
    .chk_summary(chk_summary), .rec_summary(rec_summary)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; err_in = '0; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_write(input int unit, input int ofs, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1;
    req_addr = AW'(unit * 8 + ofs); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input int unit, input int ofs, output logic [DW-1:0] d, output logic e);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(unit * 8 + ofs);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 rsp_valid on read", DW'(rsp_valid), DW'(1));
    d = rsp_rdata; e = rsp_err;
  endtask

  task automatic pulse_err(input int unit, input int b);
    @(negedge clk);
    err_in[unit*DW + b] = 1'b1;
    @(negedge clk);
    err_in = '0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d; logic e;
    do_reset();
    check("R1 req_ready", DW'(req_ready), DW'(1));
    check("R1 chk_summary", DW'(chk_summary), '0);
    check("R1 rec_summary", DW'(rec_summary), '0);
    check("R1 attn", DW'({chk_attn, rec_attn}), '0);
    check("R10 rsp_valid idle", DW'(rsp_valid), '0);
    bus_read(1, 0, d, e); check("R1 fault", d, '0);
    bus_read(1, 3, d, e); check("R1 mask", d, '1);
    bus_read(1, 6, d, e); check("R1 act0", d, '0);
    bus_read(1, 7, d, e); check("R1 act1", d, '0);
    check("R11 mapped err", DW'(e), '0);
  endtask

  task automatic t_sticky();
    logic [DW-1:0] d; logic e;
    do_reset();
    pulse_err(0, 5);
    pulse_err(0, 63);
    repeat (5) settle();
    bus_read(0, 0, d, e);
    check("R2 sticky bits", d, (64'd1 << 5) | (64'd1 << 63));
  endtask

  task automatic t_and_clear();
    logic [DW-1:0] d; logic e;
    do_reset();
    bus_write(0, 0, 64'hFF);
    bus_write(0, 1, 64'hF0);
    bus_read(0, 0, d, e);
    check("R3 and-clear", d, 64'hF0);
    // clear all while bit 2 arrives in the same cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(1); req_wdata = '0;
    err_in[2] = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; err_in = '0;
    bus_read(0, 0, d, e);
    check("R3 error wins over clear", d, 64'h4);
  endtask

  task automatic t_overwrite();
    logic [DW-1:0] d; logic e;
    do_reset();
    pulse_err(2, 1);
    bus_write(2, 0, 64'h1234_0000_0000_0008);
    bus_read(2, 0, d, e); check("R4 fault overwrite", d, 64'h1234_0000_0000_0008);
    bus_read(2, 1, d, e); check("R4 fault alias read", d, 64'h1234_0000_0000_0008);
    bus_write(2, 3, 64'h00FF);
    bus_read(2, 3, d, e); check("R4 mask overwrite", d, 64'h00FF);
    bus_read(2, 5, d, e); check("R4 mask alias read", d, 64'h00FF);
  endtask

  task automatic t_mask_or();
    logic [DW-1:0] d; logic e;
    do_reset();
    bus_write(3, 3, 64'h0F);
    bus_write(3, 5, 64'h300);
    bus_read(3, 3, d, e); check("R5 mask or-set", d, 64'h30F);
  endtask

  task automatic t_classes();
    do_reset();
    bus_write(1, 3, '0);
    pulse_err(1, 10);
    settle();
    check("R6 chk_summary", DW'(chk_summary), DW'(4'b0010));
    check("R12 chk_attn", DW'(chk_attn), DW'(1));
    check("R7 rec none", DW'(rec_summary), '0);
    bus_write(1, 7, 64'h400);
    settle();
    check("R7 rec_summary", DW'(rec_summary), DW'(4'b0010));
    check("R12 rec_attn", DW'(rec_attn), DW'(1));
    check("R6 chk cleared by act1", DW'(chk_summary), '0);
    bus_write(1, 5, 64'h400);
    settle();
    check("R6 masked quiet", DW'({chk_attn, rec_attn}), '0);
  endtask

  task automatic t_reserved();
    do_reset();
    bus_write(0, 3, '0);
    bus_write(0, 6, 64'h3);
    bus_write(0, 7, 64'h2);
    pulse_err(0, 0);
    pulse_err(0, 1);
    settle();
    check("R8 act0 codes quiet", DW'({chk_summary, rec_summary}), '0);
    check("R8 no attention", DW'({chk_attn, rec_attn}), '0);
  endtask

  task automatic t_units();
    do_reset();
    bus_write(2, 3, '0);
    bus_write(3, 3, '0);
    bus_write(3, 7, '1);
    pulse_err(2, 7);
    pulse_err(3, 7);
    pulse_err(0, 7);
    settle();
    check("R9 chk per unit", DW'(chk_summary), DW'(4'b0100));
    check("R9 rec per unit", DW'(rec_summary), DW'(4'b1000));
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] d; logic e;
    do_reset();
    bus_write(0, 2, 64'hAA);
    check("R11 write err flag", DW'(rsp_err), DW'(1));
    check("R10 write rdata zero", rsp_rdata, '0);
    bus_write(0, 4, 64'h0);
    bus_read(0, 2, d, e);
    check("R11 read data", d, '0);
    check("R11 read err", DW'(e), DW'(1));
    bus_read(0, 0, d, e); check("R11 fault untouched", d, '0);
    bus_read(0, 3, d, e); check("R11 mask untouched", d, '1);
    settle();
    check("R10 rsp_valid drops", DW'(rsp_valid), '0);
  endtask

  initial begin
    t_reset();
    t_sticky();
    t_and_clear();
    t_overwrite();
    t_mask_or();
    t_classes();
    t_reserved();
    t_units();
    t_unmapped();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule